// File: doc/BRIEF.md
# Flash Busy-Status Byte Generator

This block forms the byte that a flash array returns on a bus read while its embedded write engine is busy programming a word, erasing blocks, holding an erase in suspension, or sitting in a latched failure. It watches the engine's state flags, the bit 7 value being programmed, a per-read strobe, and two address qualifiers. The first qualifier says the read address lies in a block that is marked for erase. The second says it lies in a block whose erase failed. From these it builds a status byte and chooses between that byte and the plain array data.

The byte carries five fields that host software decodes at fixed positions. Bit 7 is a polling bit that reports the inverse of the target value until the operation ends. Bit 6 inverts on every read while the engine works. Bit 5 is a failure flag that stays set. Bit 3 shows whether the erase has actually begun. Bit 2 inverts only on reads inside the blocks of interest. The two toggling bits come from two separate flip-flops, so a host can tell busy from done with bit 6 and locate erasing or failed blocks with bit 2.

Top module: `pe_status_gen`

## Requirements
- R1: While reset is asserted, and after it is released, both toggle flip-flops are 0 and the failure flag is clear. Asserting reset clears them at once, even in the middle of an operation.
- R2: While a program is active, bit 7 is the inverse of the bit 7 value being programmed, and bits 3 and 2 read 0.
- R3: While an erase is active and not suspended, bit 7 reads 0 and the status byte is selected.
- R4: Bit 6 shows the toggle state held before a read. It then inverts after each read strobe during a program, an active erase, or a latched failure. Strobes while array data is selected leave it unchanged.
- R5: During an active erase, bit 3 follows the erase-started flag: 0 while more blocks may still be added, 1 once erasing runs.
- R6: During an active erase, bit 2 inverts only after reads whose address lies in a block marked for erase. For any other address it reads the held value and does not change.
- R7: When an erase is suspended, a read inside a marked block returns bit 7 = 1, a frozen bit 6, and bit 2 that inverts after each such read. Bits 5 and 3 read 0 in that case.
- R8: With no operation and no latched failure, or when an erase is suspended and the address is outside every marked block, the output is the array data and the status-select flag is 0.
- R9: A failure event sets bit 5 from the next cycle. The flag stays set, with the status byte still selected even when the engine is idle, until the read/reset command input is seen. If failure and clear arrive in the same cycle, clear wins.
- R10: After an erase failure, bits 5 and 3 read 1, bit 7 reads 0, and bit 2 inverts only after reads in blocks flagged as failed.
- R11: After a program failure, bit 7 still reads the inverse of the programmed bit 7 and bit 5 reads 1.
- R12: An operation-start pulse clears both toggle flip-flops at the next edge, and this takes priority over a read strobe in the same cycle.
- R13: Status bits 4, 1 and 0, and every output bit above bit 7, read 0 whenever the status byte is selected.
- R14: A program started while an erase is suspended reports program status (R2 and R4 rules) at every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_start | input | 1 | Pulse when the engine begins a new program or erase |
| prog_busy | input | 1 | Engine is programming a word |
| erase_busy | input | 1 | Engine holds an erase (running, timing, or suspended) |
| erase_susp | input | 1 | The erase is suspended |
| erase_running | input | 1 | The erase has begun; no more blocks can be added |
| prog_bit7 | input | 1 | Bit 7 of the word being programmed |
| fail_evt | input | 1 | Pulse when the current operation fails |
| reset_cmd | input | 1 | Read/reset command seen; clears a latched failure |
| rd_stb | input | 1 | One-cycle strobe per bus read |
| addr_in_erase | input | 1 | Read address lies in a block marked for erase |
| addr_in_fail | input | 1 | Read address lies in a block whose erase failed |
| array_data | input | DW | Data read from the memory array |
| rd_data | output | DW | Byte or word returned to the bus |
| status_sel | output | 1 | 1 when rd_data carries the status byte |

## Verification
The bench aims at the points where the two toggles must differ. One is a read outside the marked blocks during erase, where bit 6 must move and bit 2 must hold. Another is a suspend, where bit 6 must freeze and bit 2 keep moving. A third is an erase failure, where bit 2 moves only for failed blocks. A design that shared one flip-flop, or advanced both on every strobe, would show the wrong bit 2 within a read or two. The bench also checks that the failure flag survives an idle engine and loses to a simultaneous clear. A start pulse must clear an already-set toggle, and a program issued during suspend must override the suspend byte. Getting any of these wrong gives a stuck or spurious bit 5 or a polling bit of the wrong sense.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
  localparam int STAT_W = 8;
  localparam int POLL_B = 7;
  localparam int TOG_B  = 6;
  localparam int FAIL_B = 5;
  localparam int TMR_B  = 3;
  localparam int ATOG_B = 2;

  typedef enum logic [2:0] {
    M_ARRAY = 3'd0,
    M_PROG  = 3'd1,
    M_PERR  = 3'd2,
    M_ERASE = 3'd3,
    M_EERR  = 3'd4,
    M_SUSP  = 3'd5
  } rd_mode_e;
endpackage

// File: rtl/pe_rst_sync.sv
module pe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  always_comb begin
    sync_d = {sync_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[LAST];
endmodule

// File: rtl/pe_fail_latch.sv
module pe_fail_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_i,
  input  logic clr_i,
  input  logic prog_i,
  output logic err_o,
  output logic kind_erase_o
);
  logic err_q, err_d;
  logic kind_q, kind_d;

  always_comb begin
    err_d  = err_q;
    kind_d = kind_q;
    if (clr_i) begin
      err_d = 1'b0;
    end else if (fail_i) begin
      err_d  = 1'b1;
      kind_d = !prog_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      kind_q <= 1'b0;
    end else begin
      err_q  <= err_d;
      kind_q <= kind_d;
    end
  end

  assign err_o        = err_q;
  assign kind_erase_o = kind_q;

  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_i) |=> err_q);
  // R9
  fail_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !err_q);
  // R9
  fail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_i && !clr_i) |=> err_q);
endmodule

// File: rtl/pe_mode_decode.sv
module pe_mode_decode
  import pe_status_pkg::*;
(
  input  logic     err_i,
  input  logic     kind_erase_i,
  input  logic     prog_i,
  input  logic     erase_i,
  input  logic     susp_i,
  input  logic     in_erase_i,
  output rd_mode_e mode_o,
  output logic     sel_o
);
  always_comb begin
    if (err_i) begin
      mode_o = kind_erase_i ? M_EERR : M_PERR;
    end else if (prog_i) begin
      mode_o = M_PROG;
    end else if (erase_i && susp_i) begin
      mode_o = in_erase_i ? M_SUSP : M_ARRAY;
    end else if (erase_i) begin
      mode_o = M_ERASE;
    end else begin
      mode_o = M_ARRAY;
    end
    sel_o = (mode_o != M_ARRAY);
  end
endmodule

// File: rtl/pe_toggle_pair.sv
module pe_toggle_pair
  import pe_status_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     rd_i,
  input  rd_mode_e mode_i,
  input  logic     in_erase_i,
  input  logic     in_fail_i,
  output logic     tog_o,
  output logic     alt_o
);
  logic tog_q, tog_d;
  logic alt_q, alt_d;
  logic adv_tog, adv_alt;

  always_comb begin
    adv_tog = rd_i && ((mode_i == M_PROG)  || (mode_i == M_PERR) ||
                       (mode_i == M_ERASE) || (mode_i == M_EERR));
    adv_alt = rd_i && (((mode_i == M_ERASE) && in_erase_i) ||
                        (mode_i == M_SUSP) ||
                       ((mode_i == M_EERR)  && in_fail_i));
    tog_d = tog_q;
    alt_d = alt_q;
    if (start_i) begin
      tog_d = 1'b0;
      alt_d = 1'b0;
    end else begin
      if (adv_tog) tog_d = !tog_q;
      if (adv_alt) alt_d = !alt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      alt_q <= 1'b0;
    end else begin
      tog_q <= tog_d;
      alt_q <= alt_d;
    end
  end

  assign tog_o = tog_q;
  assign alt_o = alt_q;

  // R12
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!tog_q && !alt_q));
  // R4
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !adv_tog) |=> $stable(tog_q));
  // R6
  alt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !adv_alt) |=> $stable(alt_q));
  // R7
  susp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && mode_i == M_SUSP) |=> $stable(tog_q));
endmodule

// File: rtl/pe_byte_former.sv
module pe_byte_former
  import pe_status_pkg::*;
#(
  parameter int DW = 16
) (
  input  rd_mode_e       mode_i,
  input  logic           bit7_i,
  input  logic           running_i,
  input  logic           tog_i,
  input  logic           alt_i,
  input  logic [DW-1:0]  array_i,
  output logic [DW-1:0]  data_o
);
  logic [STAT_W-1:0] stat;

  always_comb begin
    stat = '0;
    case (mode_i)
      M_PROG: begin
        stat[POLL_B] = !bit7_i;
        stat[TOG_B]  = tog_i;
      end
      M_PERR: begin
        stat[POLL_B] = !bit7_i;
        stat[TOG_B]  = tog_i;
        stat[FAIL_B] = 1'b1;
      end
      M_ERASE: begin
        stat[TOG_B]  = tog_i;
        stat[TMR_B]  = running_i;
        stat[ATOG_B] = alt_i;
      end
      M_EERR: begin
        stat[TOG_B]  = tog_i;
        stat[FAIL_B] = 1'b1;
        stat[TMR_B]  = 1'b1;
        stat[ATOG_B] = alt_i;
      end
      M_SUSP: begin
        stat[POLL_B] = 1'b1;
        stat[TOG_B]  = tog_i;
        stat[ATOG_B] = alt_i;
      end
      default: stat = '0;
    endcase

    data_o = '0;
    if (mode_i == M_ARRAY) data_o = array_i;
    else                   data_o[STAT_W-1:0] = stat;
  end
endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
  import pe_status_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start,
  input  logic          prog_busy,
  input  logic          erase_busy,
  input  logic          erase_susp,
  input  logic          erase_running,
  input  logic          prog_bit7,
  input  logic          fail_evt,
  input  logic          reset_cmd,
  input  logic          rd_stb,
  input  logic          addr_in_erase,
  input  logic          addr_in_fail,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          status_sel
);
  logic     rst_n_s;
  logic     err;
  logic     kind_erase;
  logic     tog;
  logic     alt;
  rd_mode_e mode;

  pe_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  pe_fail_latch u_fail (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .fail_i       (fail_evt),
    .clr_i        (reset_cmd),
    .prog_i       (prog_busy),
    .err_o        (err),
    .kind_erase_o (kind_erase)
  );

  pe_mode_decode u_mode (
    .err_i        (err),
    .kind_erase_i (kind_erase),
    .prog_i       (prog_busy),
    .erase_i      (erase_busy),
    .susp_i       (erase_susp),
    .in_erase_i   (addr_in_erase),
    .mode_o       (mode),
    .sel_o        (status_sel)
  );

  pe_toggle_pair u_tog (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (op_start),
    .rd_i       (rd_stb),
    .mode_i     (mode),
    .in_erase_i (addr_in_erase),
    .in_fail_i  (addr_in_fail),
    .tog_o      (tog),
    .alt_o      (alt)
  );

  pe_byte_former #(.DW(DW)) u_form (
    .mode_i    (mode),
    .bit7_i    (prog_bit7),
    .running_i (erase_running),
    .tog_i     (tog),
    .alt_i     (alt),
    .array_i   (array_data),
    .data_o    (rd_data)
  );

  // R2
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (prog_busy && !err) |-> (status_sel && rd_data[POLL_B] == !prog_bit7));
  // R3
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (erase_busy && !erase_susp && !prog_busy && !err) |-> (status_sel && !rd_data[POLL_B]));
  // R8
  susp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (erase_busy && erase_susp && !prog_busy && !addr_in_erase && !err) |-> !status_sel);
  // R13
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    status_sel |-> (rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00));
endmodule

// File: tb/pe_status_gen_test.sv
module pe_status_gen_test;
  localparam int DW = 16;
  localparam int NV = 29;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_start, prog_busy, erase_busy, erase_susp, erase_running;
  logic          prog_bit7, fail_evt, reset_cmd, rd_stb, addr_in_erase, addr_in_fail;
  logic [DW-1:0] array_data;
  logic [DW-1:0] rd_data;
  logic          status_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = !clk;

  pe_status_gen #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .prog_busy(prog_busy),
    .erase_busy(erase_busy), .erase_susp(erase_susp), .erase_running(erase_running),
    .prog_bit7(prog_bit7), .fail_evt(fail_evt), .reset_cmd(reset_cmd), .rd_stb(rd_stb),
    .addr_in_erase(addr_in_erase), .addr_in_fail(addr_in_fail),
    .array_data(array_data), .rd_data(rd_data), .status_sel(status_sel)
  );

  // tag | prog erase susp run d7 rd inE inF start fail clr | arr | sel | expected byte
  localparam logic [59:0] VEC [NV] = '{
    {"R8  ", 11'b00000000000, 8'hA5, 1'b0, 8'hA5},
    {"R12 ", 11'b10001000100, 8'hFF, 1'b1, 8'h00},
    {"R4  ", 11'b10001100000, 8'hFF, 1'b1, 8'h00},
    {"R4  ", 11'b10001100000, 8'hFF, 1'b1, 8'h40},
    {"R2  ", 11'b10000100000, 8'hFF, 1'b1, 8'h80},
    {"R4  ", 11'b10000000000, 8'hFF, 1'b1, 8'hC0},
    {"R8  ", 11'b00000100000, 8'h5A, 1'b0, 8'h5A},
    {"R3  ", 11'b01000010100, 8'hFF, 1'b1, 8'h40},
    {"R12 ", 11'b01000110000, 8'hFF, 1'b1, 8'h00},
    {"R6  ", 11'b01000100000, 8'hFF, 1'b1, 8'h44},
    {"R5  ", 11'b01010100000, 8'hFF, 1'b1, 8'h0C},
    {"R6  ", 11'b01010110000, 8'hFF, 1'b1, 8'h4C},
    {"R5  ", 11'b01010010000, 8'hFF, 1'b1, 8'h08},
    {"R7  ", 11'b01110110000, 8'hFF, 1'b1, 8'h80},
    {"R7  ", 11'b01110110000, 8'hFF, 1'b1, 8'h84},
    {"R8  ", 11'b01110100000, 8'h99, 1'b0, 8'h99},
    {"R7  ", 11'b01110110000, 8'hFF, 1'b1, 8'h80},
    {"R14 ", 11'b11110100000, 8'hFF, 1'b1, 8'h80},
    {"R14 ", 11'b11110000010, 8'hFF, 1'b1, 8'hC0},
    {"R11 ", 11'b01110110000, 8'hFF, 1'b1, 8'hE0},
    {"R9  ", 11'b01110010001, 8'hFF, 1'b1, 8'hA0},
    {"R9  ", 11'b01110010000, 8'hFF, 1'b1, 8'h84},
    {"R5  ", 11'b01010010010, 8'hFF, 1'b1, 8'h0C},
    {"R10 ", 11'b01010110000, 8'hFF, 1'b1, 8'h2C},
    {"R10 ", 11'b01010111000, 8'hFF, 1'b1, 8'h6C},
    {"R10 ", 11'b01010111000, 8'hFF, 1'b1, 8'h28},
    {"R9  ", 11'b00000000000, 8'hFF, 1'b1, 8'h6C},
    {"R9  ", 11'b00000000011, 8'hFF, 1'b1, 8'h6C},
    {"R9  ", 11'b00000000000, 8'h11, 1'b0, 8'h11}
  };

  task automatic drive(input logic [10:0] c, input logic [7:0] arr);
    {prog_busy, erase_busy, erase_susp, erase_running, prog_bit7, rd_stb,
     addr_in_erase, addr_in_fail, op_start, fail_evt, reset_cmd} = c;
    array_data = {8'hC3, arr};
  endtask

  task automatic check(input logic [31:0] tag, input logic exp_sel, input logic [7:0] exp_b,
                       input logic [7:0] arr);
    logic [DW-1:0] exp_d;
    exp_d = exp_sel ? {8'h00, exp_b} : {8'hC3, arr};
    checks++;
    if (rd_data !== exp_d || status_sel !== exp_sel) begin
      errors++;
      $display("FAIL %s: rd_data=%h sel=%b expected rd_data=%h sel=%b",
               tag, rd_data, status_sel, exp_d, exp_sel);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(11'b0, 8'h5A);
    #2;
    check("R8  ", 1'b0, 8'h00, 8'h5A);
    // R1: in reset a program shows toggle 0
    drive(11'b10001000000, 8'hFF);
    #1;
    check("R1  ", 1'b1, 8'h00, 8'hFF);
    drive(11'b0, 8'hA5);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][27:17], VEC[i][16:9]);
      #2;
      check(VEC[i][59:28], VEC[i][8], VEC[i][7:0], VEC[i][16:9]);
      if (status_sel) begin
        checks++;
        // R13: spare status bits and upper byte stay zero
        if ((rd_data & 16'hFF13) != 16'h0000) begin
          errors++;
          $display("FAIL R13: rd_data=%h expected spare bits zero", rd_data);
        end
      end
      @(negedge clk);
    end

    // R12 and R4: fresh program, one read sets toggle
    drive(11'b10001000100, 8'hFF);
    @(negedge clk);
    drive(11'b10001100000, 8'hFF);
    @(negedge clk);
    drive(11'b10001000000, 8'hFF);
    #2;
    check("R4  ", 1'b1, 8'h40, 8'hFF);
    // R1: asynchronous reset clears the toggle at once
    rst_n = 1'b0;
    #1;
    check("R1  ", 1'b1, 8'h00, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(11'b0, 8'h3C);
    #2;
    check("R1  ", 1'b0, 8'h00, 8'h3C);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule